// File: doc/BRIEF.md
# Paddle and Ball Motion Controller

This block advances the moving objects of a two-player paddle game by one step on every video frame. A single-cycle frame tick triggers the update, and nothing moves between ticks. Each player has one pushbutton. While the button is held the paddle travels downward, and when the button is released it travels upward. A move that would carry the paddle off the playfield is refused, and the paddle stays where it was.

The ball is a square sprite with signed horizontal and vertical velocities. It reflects off the top and bottom edges of the playfield. When it reaches the inner face of a paddle it is sent back the other way. Its vertical speed is nudged by the direction that paddle is commanded to move. Its horizontal speed is raised by a hit in the centre band of the paddle and lowered by a hit anywhere else on the paddle. If a paddle is not there when the ball reaches its face, the block emits a one-cycle out-of-bounds pulse and serves the ball again from the middle of the screen.

The outputs are the top row of each paddle and the top-left corner of the ball. A display renderer consumes them.

Top module: `pong_motion_ctrl`

## Requirements
- R1: After reset, both paddles sit at row (SCREEN_H-PAD_H)/2, the ball sits at ((SCREEN_W-BALL_SZ)/2, (SCREEN_H-BALL_SZ)/2), the ball velocity is (+VX_INIT, +VY_INIT), and out_of_bounds is 0.
- R2: In a cycle where frame_tick is 0, no position output changes.
- R3: On a tick, a paddle's candidate row is its row plus PAD_STEP when its button is 1 (held, moving down), or its row minus PAD_STEP when its button is 0 (released, moving up).
- R4: The candidate row is written only if it lies within 0 to SCREEN_H-PAD_H. Otherwise the paddle keeps its row.
- R5: On a tick with no wall, paddle or miss event, the ball moves by (vx, vy).
- R6: If the new ball row would be below 0, the row becomes 0. If it would exceed SCREEN_H-BALL_SZ, the row becomes SCREEN_H-BALL_SZ. In both cases vy changes sign and keeps its magnitude.
- R7: The ball crosses the left face (LPAD_X+PAD_W) when vx<0 and its column goes from at or right of the face to left of it. It crosses the right face (RPAD_X) when vx>0 and its right edge goes from at or left of the face to beyond it. If the ball rows before the move overlap the paddle rows, the ball is placed against the face and vx changes sign.
- R8: On a paddle hit, vy (after any wall reflection) is increased by 1 if that paddle's button is 1 and decreased by 1 if it is 0. The result is clamped to -VY_MAX..+VY_MAX.
- R9: On a paddle hit, |vx| grows by 1 (up to VX_MAX) if the ball's centre row (ball_y+BALL_SZ/2) lies within the CENTRE_ROWS rows starting (PAD_H-CENTRE_ROWS)/2 below the paddle top. Otherwise |vx| shrinks by 1 (down to 1).
- R10: A face crossing without vertical overlap is a miss. The ball returns to its reset position and reset velocity, and out_of_bounds is 1 in the cycle after the tick.
- R11: out_of_bounds is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse, once per frame |
| btn_left | input | 1 | Left player button, 1 = held |
| btn_right | input | 1 | Right player button, 1 = held |
| left_pad_y | output | clog2(SCREEN_H) | Top row of left paddle |
| right_pad_y | output | clog2(SCREEN_H) | Top row of right paddle |
| ball_x | output | clog2(SCREEN_W) | Left column of ball |
| ball_y | output | clog2(SCREEN_H) | Top row of ball |
| out_of_bounds | output | 1 | One-cycle pulse after a missed ball |

## Verification
The bench builds the block on a 160x120 playfield with 4-pixel-wide paddles. Paddle height, ball size, centre band and speed limits keep their default values. On that small field the paddles reach both row limits within tens of frames, and the ball meets walls, centre hits, edge hits and misses hundreds of times in a few thousand frames. Every frame's positions and pulse are compared with an arithmetic model, so the speed clamps and the combined wall-plus-paddle cases are exercised repeatedly.

// File: rtl/pong_pkg.sv
package pong_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } pad_dir_t;

  function automatic int clamp_i(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int abs_i(input int v);
    return (v < 0) ? -v : v;
  endfunction

endpackage

// File: rtl/pong_paddle.sv
module pong_paddle
  import pong_pkg::*;
#(
  parameter int SCREEN_H = 480,
  parameter int PAD_H    = 50,
  parameter int PAD_STEP = 1,
  parameter int YW       = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          btn,
  output logic [YW-1:0] pad_y
);

  localparam int YMAX  = SCREEN_H - PAD_H;
  localparam int YHOME = YMAX / 2;

  pad_dir_t dir;
  int       cand;
  logic     cand_ok;

  always_comb begin
    dir     = pad_dir_t'(btn);
    cand    = (dir == DIR_DOWN) ? int'(pad_y) + PAD_STEP : int'(pad_y) - PAD_STEP;
    cand_ok = (cand >= 0) && (cand <= YMAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_y <= YW'(YHOME);
    end else if (tick && cand_ok) begin
      pad_y <= YW'(cand);
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(pad_y));

  assert_pad_range_R4: assert property (@(posedge clk) disable iff (rst)
    int'(pad_y) <= YMAX);

  assert_pad_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && btn && (int'(pad_y) + PAD_STEP <= YMAX)) |=>
      (int'(pad_y) == int'($past(pad_y)) + PAD_STEP));

endmodule

// File: rtl/pong_hit_eval.sv
module pong_hit_eval #(
  parameter int PAD_H       = 50,
  parameter int BALL_SZ     = 10,
  parameter int CENTRE_ROWS = 20,
  parameter int YW          = 9
) (
  input  logic [YW-1:0] ball_y,
  input  logic [YW-1:0] pad_y,
  output logic          overlap,
  output logic          centre
);

  localparam int BAND_OFS = (PAD_H - CENTRE_ROWS) / 2;

  int ball_mid;
  int band_lo;

  always_comb begin
    ball_mid = int'(ball_y) + BALL_SZ / 2;
    band_lo  = int'(pad_y) + BAND_OFS;
    overlap  = (int'(ball_y) + BALL_SZ - 1 >= int'(pad_y)) &&
               (int'(ball_y) <= int'(pad_y) + PAD_H - 1);
    centre   = (ball_mid >= band_lo) && (ball_mid <= band_lo + CENTRE_ROWS - 1);
  end

  always_comb begin
    assert_centre_in_pad_R9: assert (!centre || overlap);
  end

endmodule

// File: rtl/pong_ball.sv
module pong_ball
  import pong_pkg::*;
#(
  parameter int SCREEN_W = 640,
  parameter int SCREEN_H = 480,
  parameter int BALL_SZ  = 10,
  parameter int L_FACE   = 30,
  parameter int R_FACE   = 610,
  parameter int VX_MAX   = 4,
  parameter int VY_MAX   = 4,
  parameter int VX_INIT  = 2,
  parameter int VY_INIT  = 1,
  parameter int XW       = 10,
  parameter int YW       = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [1:0]    pad_btn,
  input  logic [1:0]    pad_ovl,
  input  logic [1:0]    pad_ctr,
  output logic [XW-1:0] ball_x,
  output logic [YW-1:0] ball_y,
  output logic          oob
);

  localparam int VMAXA = (VX_MAX > VY_MAX) ? VX_MAX : VY_MAX;
  localparam int VW    = $clog2(VMAXA + 1) + 1;
  localparam int YLIM  = SCREEN_H - BALL_SZ;
  localparam int XHOME = (SCREEN_W - BALL_SZ) / 2;
  localparam int YHOME = (SCREEN_H - BALL_SZ) / 2;

  logic signed [VW-1:0] vx, vy;

  int   nx, ny, tx, ty, nvx, nvy, mag, nmag;
  logic cross_l, cross_r, side, hit, miss;

  always_comb begin
    nx  = int'(ball_x) + int'(vx);
    ny  = int'(ball_y) + int'(vy);
    ty  = ny;
    nvy = int'(vy);
    if (ny < 0) begin
      ty  = 0;
      nvy = -int'(vy);
    end else if (ny > YLIM) begin
      ty  = YLIM;
      nvy = -int'(vy);
    end

    cross_l = (vx < 0) && (nx < L_FACE) && (int'(ball_x) >= L_FACE);
    cross_r = (vx > 0) && (nx + BALL_SZ > R_FACE) && (int'(ball_x) + BALL_SZ <= R_FACE);
    side    = cross_r;
    hit     = (cross_l || cross_r) && pad_ovl[side];
    miss    = (cross_l || cross_r) && !pad_ovl[side];

    mag  = abs_i(int'(vx));
    nmag = pad_ctr[side] ? clamp_i(mag + 1, 1, VX_MAX) : clamp_i(mag - 1, 1, VX_MAX);
    tx   = nx;
    nvx  = int'(vx);
    if (hit) begin
      tx  = cross_l ? L_FACE : R_FACE - BALL_SZ;
      nvx = cross_l ? nmag : -nmag;
      nvy = clamp_i(nvy + (pad_btn[side] ? 1 : -1), -VY_MAX, VY_MAX);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ball_x <= XW'(XHOME);
      ball_y <= YW'(YHOME);
      vx     <= VW'(VX_INIT);
      vy     <= VW'(VY_INIT);
      oob    <= 1'b0;
    end else if (tick) begin
      if (miss) begin
        ball_x <= XW'(XHOME);
        ball_y <= YW'(YHOME);
        vx     <= VW'(VX_INIT);
        vy     <= VW'(VY_INIT);
        oob    <= 1'b1;
      end else begin
        ball_x <= XW'(tx);
        ball_y <= YW'(ty);
        vx     <= VW'(nvx);
        vy     <= VW'(nvy);
        oob    <= 1'b0;
      end
    end else begin
      oob <= 1'b0;
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(ball_x) && $stable(ball_y)));

  assert_y_span_R6: assert property (@(posedge clk) disable iff (rst)
    int'(ball_y) <= YLIM);

  assert_x_span_R7: assert property (@(posedge clk) disable iff (rst)
    (int'(ball_x) >= L_FACE) && (int'(ball_x) <= R_FACE - BALL_SZ));

  assert_vy_R8: assert property (@(posedge clk) disable iff (rst)
    (int'(vy) >= -VY_MAX) && (int'(vy) <= VY_MAX));

  assert_vx_R9: assert property (@(posedge clk) disable iff (rst)
    (vx != 0) && (abs_i(int'(vx)) <= VX_MAX));

  assert_oob_tick_R10: assert property (@(posedge clk) disable iff (rst)
    oob |-> $past(tick));

  assert_oob_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    oob |=> !oob);

endmodule

// File: rtl/pong_motion_ctrl.sv
module pong_motion_ctrl #(
  parameter int SCREEN_W    = 640,
  parameter int SCREEN_H    = 480,
  parameter int PAD_H       = 50,
  parameter int PAD_W       = 10,
  parameter int LPAD_X      = 20,
  parameter int RPAD_X      = 610,
  parameter int BALL_SZ     = 10,
  parameter int PAD_STEP    = 1,
  parameter int CENTRE_ROWS = 20,
  parameter int VX_MAX      = 4,
  parameter int VY_MAX      = 4,
  parameter int VX_INIT     = 2,
  parameter int VY_INIT     = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        frame_tick,
  input  logic                        btn_left,
  input  logic                        btn_right,
  output logic [$clog2(SCREEN_H)-1:0] left_pad_y,
  output logic [$clog2(SCREEN_H)-1:0] right_pad_y,
  output logic [$clog2(SCREEN_W)-1:0] ball_x,
  output logic [$clog2(SCREEN_H)-1:0] ball_y,
  output logic                        out_of_bounds
);

  localparam int XW     = $clog2(SCREEN_W);
  localparam int YW     = $clog2(SCREEN_H);
  localparam int L_FACE = LPAD_X + PAD_W;
  localparam int R_FACE = RPAD_X;

  logic [1:0]    pad_btn;
  logic [1:0]    pad_ovl;
  logic [1:0]    pad_ctr;
  logic [YW-1:0] pad_y [2];

  assign pad_btn = {btn_right, btn_left};

  for (genvar g = 0; g < 2; g++) begin : g_side
    pong_paddle #(
      .SCREEN_H (SCREEN_H),
      .PAD_H    (PAD_H),
      .PAD_STEP (PAD_STEP),
      .YW       (YW)
    ) u_paddle (
      .clk   (clk),
      .rst   (rst),
      .tick  (frame_tick),
      .btn   (pad_btn[g]),
      .pad_y (pad_y[g])
    );

    pong_hit_eval #(
      .PAD_H       (PAD_H),
      .BALL_SZ     (BALL_SZ),
      .CENTRE_ROWS (CENTRE_ROWS),
      .YW          (YW)
    ) u_hit (
      .ball_y  (ball_y),
      .pad_y   (pad_y[g]),
      .overlap (pad_ovl[g]),
      .centre  (pad_ctr[g])
    );
  end

  pong_ball #(
    .SCREEN_W (SCREEN_W),
    .SCREEN_H (SCREEN_H),
    .BALL_SZ  (BALL_SZ),
    .L_FACE   (L_FACE),
    .R_FACE   (R_FACE),
    .VX_MAX   (VX_MAX),
    .VY_MAX   (VY_MAX),
    .VX_INIT  (VX_INIT),
    .VY_INIT  (VY_INIT),
    .XW       (XW),
    .YW       (YW)
  ) u_ball (
    .clk     (clk),
    .rst     (rst),
    .tick    (frame_tick),
    .pad_btn (pad_btn),
    .pad_ovl (pad_ovl),
    .pad_ctr (pad_ctr),
    .ball_x  (ball_x),
    .ball_y  (ball_y),
    .oob     (out_of_bounds)
  );

  assign left_pad_y  = pad_y[0];
  assign right_pad_y = pad_y[1];

endmodule

// File: tb/test_pong_motion_ctrl.sv
module test_pong_motion_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 160;
  localparam int H   = 120;
  localparam int PH  = 50;
  localparam int PW  = 4;
  localparam int LX  = 8;
  localparam int RX  = 148;
  localparam int B   = 10;
  localparam int CZ  = 20;
  localparam int VXM = 4;
  localparam int VYM = 4;
  localparam int VX0 = 2;
  localparam int VY0 = 1;
  localparam int LF  = LX + PW;
  localparam int RF  = RX;
  localparam int PYMAX = H - PH;
  localparam int FRAMES = 6000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic bl = 1'b0, br = 1'b0;
  logic [$clog2(H)-1:0] lpy, rpy, by;
  logic [$clog2(W)-1:0] bx;
  logic oob;

  int checks = 0, errors = 0;
  int epy[2], ebx, eby, evx, evy, eoob;
  int n_wall = 0, n_ctr = 0, n_edge = 0, n_miss = 0, n_lim_lo = 0, n_lim_hi = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pong_motion_ctrl #(
    .SCREEN_W(W), .SCREEN_H(H), .PAD_H(PH), .PAD_W(PW), .LPAD_X(LX), .RPAD_X(RX),
    .BALL_SZ(B), .PAD_STEP(1), .CENTRE_ROWS(CZ), .VX_MAX(VXM), .VY_MAX(VYM),
    .VX_INIT(VX0), .VY_INIT(VY0)
  ) i_pong_motion_ctrl (
    .clk(clk), .rst(rst), .frame_tick(tick), .btn_left(bl), .btn_right(br),
    .left_pad_y(lpy), .right_pad_y(rpy), .ball_x(bx), .ball_y(by),
    .out_of_bounds(oob)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clampv(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic model_frame(input logic b_l, input logic b_r);
    int nx, ny, tx, ty, nvx, nvy, s, py, mag, nm;
    bit cl, cr, ov, cen;
    logic [1:0] bt;
    bt = {b_r, b_l};
    nx = ebx + evx; ny = eby + evy;
    ty = ny; nvy = evy; tx = nx; nvx = evx; eoob = 0;
    if (ny < 0) begin ty = 0; nvy = -evy; n_wall++; end
    else if (ny > H - B) begin ty = H - B; nvy = -evy; n_wall++; end
    cl = (evx < 0) && (nx < LF) && (ebx >= LF);
    cr = (evx > 0) && (nx + B > RF) && (ebx + B <= RF);
    if (cl || cr) begin
      s  = cr ? 1 : 0;
      py = epy[s];
      ov = (eby + B - 1 >= py) && (eby <= py + PH - 1);
      if (ov) begin
        cen = (eby + B/2 >= py + (PH-CZ)/2) && (eby + B/2 <= py + (PH-CZ)/2 + CZ - 1);
        mag = (evx < 0) ? -evx : evx;
        nm  = cen ? clampv(mag + 1, 1, VXM) : clampv(mag - 1, 1, VXM);
        if (cen) n_ctr++; else n_edge++;
        nvx = cl ? nm : -nm;
        tx  = cl ? LF : RF - B;
        nvy = clampv(nvy + (bt[s] ? 1 : -1), -VYM, VYM);
      end else begin
        tx = (W - B)/2; ty = (H - B)/2; nvx = VX0; nvy = VY0; eoob = 1; n_miss++;
      end
    end
    ebx = tx; eby = ty; evx = nvx; evy = nvy;
    for (int p = 0; p < 2; p++) begin
      int c;
      c = bt[p] ? epy[p] + 1 : epy[p] - 1;
      if (c >= 0 && c <= PYMAX) epy[p] = c;
      else if (c < 0) n_lim_lo++;
      else n_lim_hi++;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    epy[0] = PYMAX/2; epy[1] = PYMAX/2;
    ebx = (W - B)/2; eby = (H - B)/2; evx = VX0; evy = VY0; eoob = 0;
    check(int'(lpy) == epy[0], "R1 left paddle", lpy, epy[0]);
    check(int'(rpy) == epy[1], "R1 right paddle", rpy, epy[1]);
    check(int'(bx) == ebx, "R1 ball x", bx, ebx);
    check(int'(by) == eby, "R1 ball y", by, eby);
    check(oob == 1'b0, "R1 out_of_bounds", oob, 0);

    for (int f = 0; f < FRAMES; f++) begin
      logic nl, nr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (f < 3000) begin
        nl = ((f / 80) % 2) == 1;
        nr = ((f / 55) % 2) == 0;
      end else begin
        nl = lfsr[0];
        nr = lfsr[5];
      end
      @(negedge clk);
      bl = nl; br = nr; tick = 1'b1;
      model_frame(nl, nr);
      @(negedge clk);
      tick = 1'b0;
      // R3 R4: paddle step and range limit
      check(int'(lpy) == epy[0], "R3 R4 left paddle", lpy, epy[0]);
      check(int'(rpy) == epy[1], "R3 R4 right paddle", rpy, epy[1]);
      // R5 R7 R9 R10: horizontal motion, face placement, speed change, serve
      check(int'(bx) == ebx, "R5 R7 R9 R10 ball x", bx, ebx);
      // R5 R6 R8: vertical motion, walls, paddle spin
      check(int'(by) == eby, "R5 R6 R8 ball y", by, eby);
      check(int'(oob) == eoob, "R10 out_of_bounds", oob, eoob);
      bl = ~nl; br = ~nr;
      @(negedge clk);
      check(int'(lpy) == epy[0] && int'(rpy) == epy[1], "R2 paddles idle", lpy, epy[0]);
      check(int'(bx) == ebx && int'(by) == eby, "R2 ball idle", bx, ebx);
      check(oob == 1'b0, "R11 pulse width", oob, 0);
    end

    check(n_wall > 0, "R6 wall events", n_wall, 1);
    check(n_ctr > 0, "R9 centre hits", n_ctr, 1);
    check(n_edge > 0, "R9 edge hits", n_edge, 1);
    check(n_miss > 0, "R10 misses", n_miss, 1);
    check(n_lim_lo > 0, "R4 top limit reached", n_lim_lo, 1);
    check(n_lim_hi > 0, "R4 bottom limit reached", n_lim_hi, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule